// File: doc/BRIEF.md
# Gated Clock Divider with Duty Control

This block derives a slower clock from a source clock for an audio sample-clock generator. A divide field `v` selects the ratio. A nonzero value divides by `v + 1`. A value of zero does not divide by one: it stops the output and holds it low. The divide field itself is therefore the enable.

In the duty-controlled variant, a second field `h` sets how many source cycles of each period the output stays high. The variant without that field produces an output as close to half duty as an integer count allows.

Settings are held in shadow registers. New settings are taken only when a period ends, so changing them never cuts a pulse short. Starting from the gated state, the first period begins with a full high phase. Stopping lets the current period run to its end, after which the output stays low.

Top module: `clkdiv_gated`

## Requirements
- R1: While the divide field is 0 and no period is in progress, `clk_out` is low; a field of 0 never yields divide-by-one.
- R2: For a divide field `v` from 1 upwards, `clk_out` repeats every `v + 1` source cycles, and the smallest ratio is 2.
- R3: With the divide field all ones, the period is `2^DIV_W` source cycles.
- R4: With `DUTY_CTRL = 1` and `h <= v`, `clk_out` is high for the first `h + 1` cycles of each period; `h = v` keeps it high for the whole period.
- R5: With `DUTY_CTRL = 1`, a high-time value `h > v` behaves exactly as `h = v`.
- R6: With `DUTY_CTRL = 0`, `clk_out` is high for the first `floor((v + 1) / 2)` cycles of each period, and the high-time field has no effect.
- R7: A change of either field made while running takes effect at the first period boundary after it, and not before.
- R8: When a nonzero value is applied while gated, `clk_out` is high at the next source-clock edge and a full period starts there.
- R9: Writing 0 while running lets the current period finish, and then `clk_out` stays low.
- R10: While `rst_n` is low, `clk_out` is low and the divider is gated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Divide field: 0 gates the output, otherwise ratio is value + 1 |
| high_val | input | DIV_W | High-time field: high for value + 1 cycles (duty variant only) |
| clk_out | output | 1 | Divided output clock |

## Verification
The hardest case to reach from the ports is a settings change, or a stop request, that arrives partway through a period. The old waveform must continue unchanged until the boundary, and only then may the new one appear. The bench starts a known configuration from the gated state and changes the fields at a chosen sample index. It then works out which index holds the next boundary and compares every later sample against the piecewise expected waveform. Every divide and high-time pair of a 4-bit configuration is also swept, each one starting from the gated state.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

  // Number of source cycles the output stays high within one period.
  // Returns 0 for a gated divider (v == 0).
  function automatic int unsigned high_cycles(int unsigned v, int unsigned h, bit duty);
    int unsigned hh;
    if (v == 0) return 0;
    if (duty) begin
      hh = (h > v) ? v : h;
      return hh + 1;
    end
    return (v + 1) / 2;
  endfunction

endpackage

// File: rtl/cdg_shadow.sv
module cdg_shadow #(
  parameter int DIV_W     = 4,
  parameter bit DUTY_CTRL = 1
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [DIV_W-1:0] hi_in,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W:0]   hic_q,
  output logic [DIV_W-1:0] div_nx,
  output logic [DIV_W:0]   hic_nx
);
  import cdg_pkg::*;
  localparam int HW = DIV_W + 1;

  logic [HW-1:0] hic_calc;

  generate
    if (DUTY_CTRL) begin : g_duty
      assign hic_calc = HW'(high_cycles(int'(div_in), int'(hi_in), 1'b1));
    end else begin : g_half
      logic unused_hi;
      assign unused_hi = ^hi_in;
      assign hic_calc  = HW'(high_cycles(int'(div_in), 0, 1'b0));
    end
  endgenerate

  assign div_nx = load ? div_in   : div_q;
  assign hic_nx = load ? hic_calc : hic_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      hic_q <= '0;
    end else begin
      div_q <= div_nx;
      hic_q <= hic_nx;
    end
  end

  // R7: settings are frozen between period boundaries
  p_hold_mid_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
    (div_q != '0 && !load) |=> ($stable(div_q) && $stable(hic_q)));

  // R4: high phase spans at least one cycle and never exceeds the period
  p_hic_range_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
    (div_q != '0) |-> (hic_q != '0 && hic_q <= ({1'b0, div_q} + 1'b1)));

endmodule

// File: rtl/cdg_count.sv
module cdg_count #(
  parameter int DIV_W = 4
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             load,
  input  logic             running,
  output logic [DIV_W-1:0] cnt_q,
  output logic [DIV_W-1:0] cnt_nx
);
  always_comb begin
    if (load)         cnt_nx = '0;
    else if (running) cnt_nx = cnt_q + 1'b1;
    else              cnt_nx = cnt_q;
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // R2: mid-period the count advances by exactly one
  p_step_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    (running && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cdg_wave.sv
module cdg_wave #(
  parameter int DIV_W = 4
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_nx,
  input  logic [DIV_W:0]   hic_nx,
  input  logic [DIV_W-1:0] cnt_nx,
  output logic             clk_out
);
  logic out_d;
  assign out_d = (div_nx != '0) && ({1'b0, cnt_nx} < hic_nx);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= out_d;
  end
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated #(
  parameter int DIV_W     = 4,
  parameter bit DUTY_CTRL = 1
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic [DIV_W-1:0] high_val,
  output logic             clk_out
);
  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] div_q, div_nx, cnt_q, cnt_nx;
  logic [HW-1:0]    hic_q, hic_nx;
  logic             running, period_end;

  assign running    = (div_q != '0);
  assign period_end = !running || (cnt_q == div_q);

  cdg_shadow #(.DIV_W(DIV_W), .DUTY_CTRL(DUTY_CTRL)) u_shadow (
    .clk_src(clk_src), .rst_n(rst_n), .load(period_end),
    .div_in(div_val), .hi_in(high_val),
    .div_q(div_q), .hic_q(hic_q), .div_nx(div_nx), .hic_nx(hic_nx)
  );

  cdg_count #(.DIV_W(DIV_W)) u_count (
    .clk_src(clk_src), .rst_n(rst_n), .load(period_end), .running(running),
    .cnt_q(cnt_q), .cnt_nx(cnt_nx)
  );

  cdg_wave #(.DIV_W(DIV_W)) u_wave (
    .clk_src(clk_src), .rst_n(rst_n), .div_nx(div_nx), .hic_nx(hic_nx),
    .cnt_nx(cnt_nx), .clk_out(clk_out)
  );

  // R1: a gated divider drives a low output
  p_gated_low_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
    !running |-> !clk_out);

  // R2: the last count of a period is followed by count zero
  p_wrap_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    (running && period_end) |=> (cnt_q == '0));

  // R8: every period opens with the output high
  p_first_high_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
    (running && cnt_q == '0) |-> clk_out);

endmodule

// File: tb/sim_clkdiv_gated.sv
`timescale 1ns/1ps
module sim_clkdiv_gated;
  localparam int W = 4;
  localparam int VMAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] div_val = '0;
  logic [W-1:0] high_val = '0;
  logic out0, out1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_gated #(.DIV_W(W), .DUTY_CTRL(1'b1)) u0 (
    .clk_src(clk), .rst_n(rst_n), .div_val(div_val), .high_val(high_val), .clk_out(out0));
  clkdiv_gated #(.DIV_W(W), .DUTY_CTRL(1'b0)) u1 (
    .clk_src(clk), .rst_n(rst_n), .div_val(div_val), .high_val(high_val), .clk_out(out1));

  // Expected high-phase length, written independently of the design.
  function automatic int exp_high(bit duty, int v, int h);
    if (v == 0) return 0;
    if (!duty) return (v + 1) >> 1;
    if (h >= v) return v + 1;
    return h + 1;
  endfunction

  task automatic report(bit ok, string tag, int idx, bit act, bit exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s sample %0d: actual %0b expected %0b", tag, idx, act, exp);
    end
  endtask

  task automatic go_gated();
    @(negedge clk);
    div_val = '0;
    repeat (2 * (VMAX + 1) + 4) @(negedge clk);
  endtask

  // Start (v,h) from the gated state and compare 2 periods of both variants.
  task automatic run_cfg(int v, int h, string tag0, string tag1);
    bit ok0 = 1, ok1 = 1, a0 = 0, e0 = 0, a1 = 0, e1 = 0;
    int bi0 = 0, bi1 = 0;
    int p = v + 1;
    int n = (v == 0) ? 20 : 2 * p;
    go_gated();
    div_val = W'(v);
    high_val = W'(h);
    for (int i = 0; i < n; i++) begin
      bit x0, x1;
      @(negedge clk);
      x0 = (v != 0) && ((i % p) < exp_high(1'b1, v, h));
      x1 = (v != 0) && ((i % p) < exp_high(1'b0, v, h));
      if (i == 0 && v != 0) report(out0 == 1'b1, "R8 first sample high", i, out0, 1'b1);
      if (ok0 && out0 !== x0) begin ok0 = 0; a0 = out0; e0 = x0; bi0 = i; end
      if (ok1 && out1 !== x1) begin ok1 = 0; a1 = out1; e1 = x1; bi1 = i; end
    end
    report(ok0, tag0, bi0, a0, e0);
    report(ok1, tag1, bi1, a1, e1);
  endtask

  // Run (va,ha), switch to (vb,hb) at sample ci, check the piecewise waveform (R7/R9).
  task automatic run_change(int va, int ha, int vb, int hb, int ci, int n, string tag);
    bit ok0 = 1, ok1 = 1, a0 = 0, e0 = 0, a1 = 0, e1 = 0;
    int bi0 = 0, bi1 = 0;
    int pa = va + 1, pb = vb + 1;
    int jb = ((ci + 1 + pa - 1) / pa) * pa;
    go_gated();
    div_val = W'(va);
    high_val = W'(ha);
    for (int i = 0; i < n; i++) begin
      bit x0, x1;
      @(negedge clk);
      if (i < jb) begin
        x0 = (i % pa) < exp_high(1'b1, va, ha);
        x1 = (i % pa) < exp_high(1'b0, va, ha);
      end else begin
        x0 = (vb != 0) && (((i - jb) % pb) < exp_high(1'b1, vb, hb));
        x1 = (vb != 0) && (((i - jb) % pb) < exp_high(1'b0, vb, hb));
      end
      if (ok0 && out0 !== x0) begin ok0 = 0; a0 = out0; e0 = x0; bi0 = i; end
      if (ok1 && out1 !== x1) begin ok1 = 0; a1 = out1; e1 = x1; bi1 = i; end
      if (i == ci) begin
        div_val = W'(vb);
        high_val = W'(hb);
      end
    end
    report(ok0, {tag, " duty variant"}, bi0, a0, e0);
    report(ok1, {tag, " half variant"}, bi1, a1, e1);
  endtask

  initial begin
    // R10: low during reset
    repeat (3) @(negedge clk);
    report(out0 == 1'b0 && out1 == 1'b0, "R10 reset low", 0, out0 | out1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: zero field after reset keeps output low
    begin
      bit ok = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (out0 !== 1'b0 || out1 !== 1'b0) ok = 0;
      end
      report(ok, "R1 gated after reset", 0, out0 | out1, 1'b0);
    end
    // Full sweep: R1 (v=0), R2/R4, R5 (h>v), R3 (all ones), R6 (half variant)
    for (int v = 0; v <= VMAX; v++) begin
      for (int h = 0; h <= VMAX; h++) begin
        string t0, t1;
        if (v == 0)      begin t0 = "R1 gated duty"; t1 = "R1 gated half"; end
        else if (v == VMAX) begin t0 = "R3 max ratio duty"; t1 = "R3 max ratio half"; end
        else if (h > v)  begin t0 = "R5 clamp"; t1 = "R6 half, high field ignored"; end
        else             begin t0 = "R2 R4 period and high time"; t1 = "R2 R6 half duty"; end
        run_cfg(v, h, t0, t1);
      end
    end
    // R7: mid-period changes only at the boundary
    run_change(5, 2, 3, 0, 3, 40, "R7 change mid period");
    run_change(7, 7, 2, 1, 11, 40, "R7 change late in period");
    run_change(1, 0, 15, 9, 0, 50, "R7 change right after start");
    run_change(4, 1, 4, 3, 4, 30, "R7 change on last count");
    // R9: stop finishes the current period, then low
    run_change(6, 3, 0, 0, 2, 40, "R9 stop mid period");
    run_change(15, 15, 0, 5, 14, 50, "R9 stop during constant high");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule